// File: doc/BRIEF.md
# Programmable Flag Port with Interrupt Requests

This block runs an eight-pin general-purpose flag port whose pins serve two roles at once. Each pin can be an input or an output flag, chosen by a direction register. The upper four pins also raise interrupt requests, and they keep doing so whatever their direction. Because an output pin takes part in interrupt detection at the value it drives, a software write to the data register can raise an interrupt. Pin 4 detects falling edges. Pins 5 and 6 are level-sensitive and active low. Pin 7 is level- or edge-sensitive, chosen by a configuration bit.

The low four pins also act as boot straps. They are captured as four mode bits while reset is asserted, and the value held at the release of reset is kept. After that the low pins are ordinary flags and the mode bits do not change. Mode bit 2 picks the memory-pin arrangement, which the block brings out as a separate output for the pin multiplexer elsewhere in the chip.

Software reaches the port through a small register interface with a write strobe and a combinational read. Input pins pass through a two-flop synchroniser before any use. Each interrupt output is registered.

Top module: `flagport`

## Requirements
- R1: During and straight after reset, every pin is an input (`pin_oe_o` = 0), every interrupt output is low, and the direction register (address 1), mask register (address 2) and configuration register (address 4) read as 0.
- R2: A write to the direction register (address 1) sets `pin_oe_o` to the written value after the write edge. The data register (address 0) drives `pin_o` with its value.
- R3: A read of the data register returns the stored value in bits whose direction bit is 1. In bits whose direction bit is 0 it returns the pin input, seen two clock edges after the input changes.
- R4: A level-sensitive pin (pins 5 and 6, and pin 7 while configuration bit 0 is 0) drives its `irq_o` bit high while its effective value is low and its mask bit is 1. The effective value is the data-register bit for an output pin and the synchronised input for an input pin. Nothing is latched: the request drops once the pin goes high or the mask bit is cleared.
- R5: An edge-sensitive pin (pin 4, and pin 7 while configuration bit 0 is 1) sets its pending bit on a falling edge of its effective value, whatever its mask bit. Its `irq_o` bit is the pending bit ANDed with the mask bit. Pending bits read at address 3 and stay set after the pin returns high.
- R6: Writing to address 3 clears each pending bit written as 1 and leaves pending bits written as 0 unchanged. A falling edge in the same cycle wins over the clear.
- R7: A pin set as an output and driven low by a data-register write raises its interrupt. A level pin's request appears one edge after the write edge. An edge pin's request appears two edges after it.
- R8: Configuration register bit 0 (address 4) selects sensing for pin 7: 0 is level and 1 is falling edge. It resets to 0 and reads back.
- R9: `mode_o` holds the value of pins 3..0 sampled on the last clock edge with `rst_n` low, and it stays fixed while reset is deasserted, whatever those pins do.
- R10: `host_mode_o` equals mode bit 2. A 1 selects the multiplexed host-port arrangement, and a 0 selects the full 14-bit address and 24-bit data arrangement.
- R11: Pins 0 to 3 never raise an interrupt: `irq_o[3:0]` stays 0 for any mask and pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode straps are sampled while it is low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 data, 1 direction, 2 mask, 3 pending/clear, 4 configuration) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational register read data |
| pin_i | input | 8 | Pin input values from the pads |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |
| irq_o | output | 8 | Per-pin interrupt requests, active high |
| mode_o | output | 4 | Mode bits captured from pins 3..0 during reset |
| host_mode_o | output | 1 | Memory-pin arrangement select (mode bit 2) |

## Verification
Each result has a fixed latency. A pin input change is visible in a data-register read two edges later. A level request from a pin change appears three edges later. An edge request from a pin change appears within four edges. A write lands on its own edge, a level or mask change reaches `irq_o` one edge after the write, and a write that makes an edge pin fall reaches `irq_o` two edges after the write. Every stimulus is applied on the falling clock edge, and the bench then waits exactly the stated number of falling edges before it samples, checking the quiet cycles before a request is due as well as the cycle it arrives. Pulses on edge pins are held across two rising edges so the synchroniser cannot miss them.

// File: rtl/flagport_pkg.sv
// Shared constants for the flag port: register addresses and per-pin sensing kinds.
// Assumes an eight-entry pin numbering where pins 4..7 carry interrupt roles.
package flagport_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;

    typedef enum logic [1:0] {
        SENSE_NONE,
        SENSE_LEVEL,
        SENSE_EDGE,
        SENSE_SELECT
    } sense_e;

    // Interrupt role of each pin index
    function automatic sense_e pin_sense(input int unsigned idx);
        case (idx)
            7:       return SENSE_SELECT;
            6, 5:    return SENSE_LEVEL;
            4:       return SENSE_EDGE;
            default: return SENSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/flagport_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; resets to all zeros.
module flagport_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw pins through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/flagport_regs.sv
// Register file of the flag port: data, direction, mask and sense configuration,
// clear strobes for pending bits and the combinational read mux.
// Assumes single-cycle write strobes and a combinational read path.
module flagport_regs
    import flagport_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      pin_sync_i,
    input  logic [W-1:0]      pending_i,
    output logic [W-1:0]      data_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      mask_o,
    output logic              cfg_edge_o,
    output logic [W-1:0]      clr_o,
    output logic [W-1:0]      rdata_o
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] mask_q;
    logic         cfg_q;

    // Update the writable registers on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
            cfg_q  <= 1'b0;
        end else if (we_i) begin
            if (addr_i == A_DATA) data_q <= wdata_i;
            if (addr_i == A_DIR)  dir_q  <= wdata_i;
            if (addr_i == A_MASK) mask_q <= wdata_i;
            if (addr_i == A_CFG)  cfg_q  <= wdata_i[0];
        end
    end

    // Per-pin clear strobes from a write to the pending address
    assign clr_o = (we_i && addr_i == A_PEND) ? wdata_i : '0;

    // Select the read value by address
    always_comb begin
        case (addr_i)
            A_DATA:  rdata_o = (dir_q & data_q) | (~dir_q & pin_sync_i);
            A_DIR:   rdata_o = dir_q;
            A_MASK:  rdata_o = mask_q;
            A_PEND:  rdata_o = pending_i;
            A_CFG:   rdata_o = {{(W-1){1'b0}}, cfg_q};
            default: rdata_o = '0;
        endcase
    end

    assign data_o     = data_q;
    assign dir_o      = dir_q;
    assign mask_o     = mask_q;
    assign cfg_edge_o = cfg_q;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we_i) && $past(addr_i) == A_DIR |-> dir_o == $past(wdata_i)); // R2

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we_i) && $past(addr_i) == A_DATA |-> data_o == $past(wdata_i)); // R2

endmodule

// File: rtl/flagport_irq_cell.sv
// Interrupt detection for one pin. The sensing kind is fixed by parameter:
// none, active-low level, falling-edge with pending bit, or selectable.
// Assumes the effective pin value is already synchronous to clk.
module flagport_irq_cell
    import flagport_pkg::*;
#(
    parameter sense_e SENSE = SENSE_NONE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eff_i,
    input  logic mask_i,
    input  logic edge_sel_i,
    input  logic clr_i,
    output logic pending_o,
    output logic irq_o
);

    if (SENSE == SENSE_NONE) begin : g_none
        assign pending_o = 1'b0;
        assign irq_o     = 1'b0;
    end else begin : g_active
        logic prev_q;
        logic pend_q;
        logic irq_q;
        logic use_edge;
        logic fall;
        logic cond;

        assign use_edge = (SENSE == SENSE_EDGE) || (SENSE == SENSE_SELECT && edge_sel_i);
        assign fall     = prev_q && !eff_i;
        assign cond     = use_edge ? pend_q : !eff_i;

        // Remember the last effective value for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= eff_i;
        end

        // Latch falling edges; a new edge wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n)                pend_q <= 1'b0;
            else if (use_edge && fall) pend_q <= 1'b1;
            else if (clr_i)            pend_q <= 1'b0;
        end

        // Register the masked request
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= cond && mask_i;
        end

        assign pending_o = pend_q;
        assign irq_o     = irq_q;

        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q && !clr_i |=> pend_q); // R5

        AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(mask_i) |-> !irq_q); // R4

        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i && !(use_edge && fall) |=> !pend_q); // R6
    end

endmodule

// File: rtl/flagport.sv
// Top of the programmable flag port. Captures mode straps from the low pins
// while reset is held, synchronises pin inputs, forms the effective pin value
// (driven value for outputs, synchronised input otherwise) and feeds it to
// per-pin interrupt cells. Assumes pin_i is asynchronous and rst_n synchronous.
module flagport
    import flagport_pkg::*;
#(
    parameter int unsigned NPINS    = 8,
    parameter int unsigned MODE_W   = 4,
    parameter int unsigned HOST_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [NPINS-1:0]  reg_wdata_i,
    output logic [NPINS-1:0]  reg_rdata_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic [NPINS-1:0]  irq_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              host_mode_o
);

    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  data_q;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  mask_q;
    logic [NPINS-1:0]  clr;
    logic [NPINS-1:0]  pending;
    logic [NPINS-1:0]  eff;
    logic              cfg_edge;
    logic [MODE_W-1:0] mode_q;

    // Sample the strap pins on every reset edge; the last one before release is kept
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= pin_i[MODE_W-1:0];
    end

    assign mode_o      = mode_q;
    assign host_mode_o = mode_q[HOST_BIT];

    flagport_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    flagport_regs #(.W(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .pin_sync_i (pin_sync),
        .pending_i  (pending),
        .data_o     (data_q),
        .dir_o      (dir_q),
        .mask_o     (mask_q),
        .cfg_edge_o (cfg_edge),
        .clr_o      (clr),
        .rdata_o    (reg_rdata_o)
    );

    assign eff      = (dir_q & data_q) | (~dir_q & pin_sync);
    assign pin_o    = data_q;
    assign pin_oe_o = dir_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        flagport_irq_cell #(.SENSE(pin_sense(i))) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .eff_i      (eff[i]),
            .mask_i     (mask_q[i]),
            .edge_sel_i (cfg_edge),
            .clr_i      (clr[i]),
            .pending_o  (pending[i]),
            .irq_o      (irq_o[i])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pin_oe_o == '0 && irq_o == '0); // R1

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o)); // R9

    AST_HOST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_o == mode_o[HOST_BIT]); // R10

endmodule

// File: tb/flagport_test.sv
// Directed bench for the flag port: one task per scenario, each checking its results.
module flagport_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pins = 8'hFF;
    logic [7:0] pout;
    logic [7:0] poe;
    logic [7:0] irq;
    logic [3:0] mode;
    logic       host;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    flagport uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pin_i       (pins),
        .pin_o       (pout),
        .pin_oe_o    (poe),
        .irq_o       (irq),
        .mode_o      (mode),
        .host_mode_o (host)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset(input logic [3:0] strap);
        rst_n = 1'b0;
        pins  = {4'hF, strap};
        step(4);
        rst_n = 1'b1;
        step(1);
    endtask

    // R1, R9, R10: reset state and strap capture with mode C set
    task automatic t_reset;
        logic [7:0] v;
        do_reset(4'b0100);
        chk("R1 pin_oe after reset", poe, 8'h00);
        chk("R1 irq after reset", irq, 8'h00);
        rd(3'd1, v); chk("R1 dir reads 0", v, 8'h00);
        rd(3'd2, v); chk("R1 mask reads 0", v, 8'h00);
        rd(3'd4, v); chk("R1 cfg reads 0", v, 8'h00);
        chk("R9 mode captured", {4'h0, mode}, 8'h04);
        chk("R10 host mode set", {7'h0, host}, 8'h01);
        pins[3:0] = 4'b1011;
        step(5);
        chk("R9 mode stable after release", {4'h0, mode}, 8'h04);
        pins = 8'hFF;
        step(3);
    endtask

    // R2, R3: outputs drive the data register; reads mix stored and pin values
    task automatic t_output;
        logic [7:0] v;
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h0F);
        chk("R2 pin_oe follows dir", poe, 8'h0F);
        chk("R2 pin_o drives data", pout, 8'h05);
        step(2);
        rd(3'd0, v); chk("R3 read mixed", v, 8'hF5);
        pins[7] = 1'b0;
        pins[0] = 1'b0;
        step(1);
        rd(3'd0, v); chk("R3 input not yet visible", v, 8'hF5);
        step(1);
        rd(3'd0, v); chk("R3 input visible, output kept", v, 8'h75);
        chk("R4 no irq while masked", irq, 8'h00);
        pins = 8'hFF;
        wr(3'd1, 8'h00);
        step(3);
    endtask

    // R4: level requests follow the pin and the mask without latching
    task automatic t_level;
        wr(3'd2, 8'h60);
        pins[5] = 1'b0;
        step(2);
        chk("R4 level not yet due", irq, 8'h00);
        step(1);
        chk("R4 level asserted", irq, 8'h20);
        pins[5] = 1'b1;
        step(3);
        chk("R4 level drops, no latch", irq, 8'h00);
        wr(3'd2, 8'h20);
        pins[6] = 1'b0;
        step(3);
        chk("R4 masked level pin quiet", irq, 8'h00);
        wr(3'd2, 8'h60);
        step(1);
        chk("R4 unmask raises level", irq, 8'h40);
        pins[6] = 1'b1;
        wr(3'd2, 8'h00);
        step(3);
    endtask

    // R5, R6: falling edges latch; clearing by write-one
    task automatic t_edge;
        logic [7:0] v;
        wr(3'd2, 8'h10);
        pins[4] = 1'b0;
        step(2);
        pins[4] = 1'b1;
        step(4);
        chk("R5 edge request latched", irq, 8'h10);
        rd(3'd3, v); chk("R5 pending after pin high", v, 8'h10);
        wr(3'd3, 8'h00);
        step(1);
        chk("R6 zero write keeps request", irq, 8'h10);
        wr(3'd3, 8'h10);
        rd(3'd3, v); chk("R6 pending cleared", v, 8'h00);
        step(1);
        chk("R6 request dropped", irq, 8'h00);
        wr(3'd2, 8'h00);
        pins[4] = 1'b0;
        step(2);
        pins[4] = 1'b1;
        step(4);
        chk("R5 masked edge quiet", irq, 8'h00);
        rd(3'd3, v); chk("R5 masked edge pending", v, 8'h10);
        wr(3'd2, 8'h10);
        step(1);
        chk("R5 unmask reveals pending", irq, 8'h10);
        wr(3'd3, 8'h10);
        wr(3'd2, 8'h00);
        step(2);
    endtask

    // R7: a data write on output pins raises interrupts
    task automatic t_concurrent;
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h30);
        step(3);
        chk("R7 idle outputs high", irq, 8'h00);
        wr(3'd0, 8'hCF);
        chk("R7 nothing at write edge", irq, 8'h00);
        step(1);
        chk("R7 level from write", irq, 8'h20);
        step(1);
        chk("R7 edge from write", irq, 8'h30);
        rd(3'd3, v); chk("R7 edge pending from write", v, 8'h10);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h10);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'hFF);
        step(3);
        chk("R7 cleaned up", irq, 8'h00);
    endtask

    // R8: pin 7 sensing selection
    task automatic t_cfg;
        logic [7:0] v;
        wr(3'd2, 8'h80);
        pins[7] = 1'b0;
        step(3);
        chk("R8 pin7 level mode", irq, 8'h80);
        pins[7] = 1'b1;
        step(3);
        chk("R8 pin7 level drops", irq, 8'h00);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R8 cfg reads back", v, 8'h01);
        pins[7] = 1'b0;
        step(2);
        pins[7] = 1'b1;
        step(4);
        chk("R8 pin7 edge latched", irq, 8'h80);
        rd(3'd3, v); chk("R8 pin7 pending", v, 8'h80);
        wr(3'd3, 8'h80);
        step(1);
        chk("R8 pin7 cleared", irq, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    // R11: low pins never interrupt
    task automatic t_lowpins;
        wr(3'd2, 8'hFF);
        pins[3:0] = 4'h0;
        step(4);
        chk("R11 low pins quiet", irq, 8'h00);
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'hF0);
        step(3);
        chk("R11 low outputs quiet", irq, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        pins = 8'hFF;
        step(3);
    endtask

    // R9, R10: second reset with mode C clear
    task automatic t_mode2;
        do_reset(4'b1011);
        chk("R9 mode recaptured", {4'h0, mode}, 8'h0B);
        chk("R10 full memory mode", {7'h0, host}, 8'h00);
        chk("R1 outputs off after reset", poe, 8'h00);
    endtask

    initial begin
        step(1);
        t_reset();
        t_output();
        t_level();
        t_edge();
        t_concurrent();
        t_cfg();
        t_lowpins();
        t_mode2();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule